// File: doc/BRIEF.md
# Logic Analyzer Capture Sequencer

This block decides when samples are stored in the circular sample memory of an on-chip logic analyzer. It drives a write enable, a write pointer and a read pointer, and it reports its current phase on a state output. When a capture ends, the read pointer marks the oldest stored sample. The sample memory, the trigger comparators and register access all sit outside the block.

The block has three capture modes. Immediate mode fills the whole buffer as soon as it is started. Single-shot mode first fills a programmable pre-trigger window, then keeps writing circularly until the trigger arrives, and then completes the remaining part of the buffer. Incremental mode stores one sample on each cycle in which the trigger is high. The mode code and the pre-trigger length are latched when a start request is accepted. A stop request returns the block to idle from any state.

Top module: `capture_sequencer`

## Requirements
- R1: While reset is high and on the first cycle after it, state_o is IDLE (code 0), wr_ptr and rd_ptr are 0, and wr_en is 0.
- R2: In IDLE, a start_req with mode_sel 0 (single-shot), 1 (immediate) or 2 (incremental) is accepted, and mode_sel and pretrig_len are latched. For modes 0 and 1, wr_en is high in the cycle after start_req. A start_req with mode_sel 3 is ignored and the block stays in IDLE.
- R3: In immediate mode, wr_en stays high for DEPTH cycles while wr_ptr counts 0 to DEPTH-1 and rd_ptr holds 0. The state codes are 3 (RUN) and then 5 (DONE), and the block ends with wr_ptr = DEPTH-1.
- R4: In single-shot mode, the block writes pretrig_len samples at wr_ptr 0 to pretrig_len-1 with rd_ptr at 0, in state FILL (code 1). It then enters ARMED (code 2) with wr_ptr = pretrig_len. If pretrig_len is 0, it enters ARMED straight from IDLE.
- R5: In ARMED, each cycle without trigger writes a sample and advances both wr_ptr and rd_ptr by one, modulo DEPTH.
- R6: A trigger seen in ARMED writes the trigger sample. DEPTH-pretrig_len samples are written in total from the trigger onward, and in DONE (wr_ptr+1) mod DEPTH equals rd_ptr. If trig_in is already high when the fill ends, no extra cycle is spent waiting (DEPTH 8, length 4 ends with wr_ptr 7).
- R7: In incremental mode (state code 4), wr_en equals trig_in. wr_ptr advances only on trigger cycles, and the block enters DONE after DEPTH stored samples, with wr_ptr = DEPTH-1.
- R8: In DONE, wr_en is 0 and both pointers hold their values.
- R9: A stop_req moves the block to IDLE from any state and clears both pointers. It takes priority over start_req.
- R10: A start_req outside IDLE has no effect on state or pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request to begin a capture |
| stop_req | input | 1 | Request to abort and return to idle |
| trig_in | input | 1 | Trigger condition from the comparators |
| mode_sel | input | 2 | Capture mode: 0 single-shot, 1 immediate, 2 incremental |
| pretrig_len | input | AW | Number of pre-trigger samples in single-shot mode |
| state_o | output | 3 | Current phase: 0 IDLE, 1 FILL, 2 ARMED, 3 RUN, 4 INCR, 5 DONE |
| wr_en | output | 1 | Sample memory write enable |
| wr_ptr | output | AW | Sample memory write address |
| rd_ptr | output | AW | Oldest-sample address |

## Verification
The bench targets the edges of the pre-trigger window: a length of 0, where a design that insists on a fill cycle writes one sample too many, and a length of DEPTH-1, where a design that always moves to RUN after the trigger overwrites the oldest sample. It also holds the trigger high across the end of the fill, where a design that waits a cycle gives a final pointer other than DEPTH-1. Long waits in ARMED make both pointers wrap, which catches a read pointer that never moves or that fails to wrap. Stops, restarts, reserved mode codes and stray start requests are mixed in at random, which exposes a design that restarts from DONE or lets start override stop.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [2:0] {
        CS_IDLE  = 3'd0,
        CS_FILL  = 3'd1,
        CS_ARMED = 3'd2,
        CS_RUN   = 3'd3,
        CS_INCR  = 3'd4,
        CS_DONE  = 3'd5
    } cap_state_e;

    typedef enum logic [1:0] {
        CM_SINGLE      = 2'd0,
        CM_IMMEDIATE   = 2'd1,
        CM_INCREMENTAL = 2'd2,
        CM_RESERVED    = 2'd3
    } cap_mode_e;

    // Pointer commands issued by the sequencer each cycle.
    typedef struct packed {
        logic clear;
        logic adv_wr;
        logic adv_rd;
    } ptr_cmd_t;

    localparam int unsigned PTR_COUNT = 2;
    localparam int unsigned PTR_WR    = 0;
    localparam int unsigned PTR_RD    = 1;

endpackage

// File: rtl/cap_ring_ctr.sv
module cap_ring_ctr #(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          adv,
    output logic [AW-1:0] q
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [AW-1:0] q_inc;

    assign q_inc = (q == LAST) ? '0 : q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= '0;
        end else if (adv) begin
            q <= q_inc;
        end
    end
endmodule

// File: rtl/cap_seq_fsm.sv
module cap_seq_fsm
    import cap_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_req,
    input  logic          stop_req,
    input  logic          trig_in,
    input  logic [1:0]    mode_sel,
    input  logic [AW-1:0] pretrig_len,
    input  logic [AW-1:0] wp,
    input  logic [AW-1:0] rp,
    output cap_state_e    state,
    output ptr_cmd_t      cmd,
    output logic          wr_en
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    cap_state_e    state_nxt;
    logic [AW-1:0] len_q;
    logic          load;
    logic [AW-1:0] wp_inc;
    logic          ring_full;

    assign wp_inc    = (wp == LAST) ? '0 : wp + 1'b1;
    assign ring_full = (wp_inc == rp);

    always_comb begin
        state_nxt = state;
        cmd       = '0;
        load      = 1'b0;
        if (stop_req) begin
            state_nxt = CS_IDLE;
            cmd.clear = 1'b1;
        end else begin
            unique case (state)
                CS_IDLE: begin
                    if (start_req && cap_mode_e'(mode_sel) != CM_RESERVED) begin
                        load      = 1'b1;
                        cmd.clear = 1'b1;
                        unique case (cap_mode_e'(mode_sel))
                            CM_IMMEDIATE:   state_nxt = CS_RUN;
                            CM_INCREMENTAL: state_nxt = CS_INCR;
                            default:        state_nxt = (pretrig_len == '0) ? CS_ARMED : CS_FILL;
                        endcase
                    end
                end
                CS_FILL: begin
                    cmd.adv_wr = 1'b1;
                    if (wp == len_q - 1'b1) begin
                        state_nxt = CS_ARMED;
                    end
                end
                CS_ARMED: begin
                    if (trig_in) begin
                        if (ring_full) begin
                            state_nxt = CS_DONE;
                        end else begin
                            cmd.adv_wr = 1'b1;
                            state_nxt  = CS_RUN;
                        end
                    end else begin
                        cmd.adv_wr = 1'b1;
                        cmd.adv_rd = 1'b1;
                    end
                end
                CS_RUN: begin
                    if (ring_full) begin
                        state_nxt = CS_DONE;
                    end else begin
                        cmd.adv_wr = 1'b1;
                    end
                end
                CS_INCR: begin
                    if (trig_in) begin
                        if (ring_full) begin
                            state_nxt = CS_DONE;
                        end else begin
                            cmd.adv_wr = 1'b1;
                        end
                    end
                end
                CS_DONE: state_nxt = CS_DONE;
                default: begin
                    state_nxt = CS_IDLE;
                    cmd.clear = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CS_IDLE;
            len_q <= '0;
        end else begin
            state <= state_nxt;
            if (load) begin
                len_q <= pretrig_len;
            end
        end
    end

    always_comb begin
        unique case (state)
            CS_FILL, CS_ARMED, CS_RUN: wr_en = 1'b1;
            CS_INCR:                   wr_en = trig_in;
            default:                   wr_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/capture_sequencer.sv
module capture_sequencer
    import cap_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_req,
    input  logic          stop_req,
    input  logic          trig_in,
    input  logic [1:0]    mode_sel,
    input  logic [AW-1:0] pretrig_len,
    output logic [2:0]    state_o,
    output logic          wr_en,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr
);
    cap_state_e    state;
    ptr_cmd_t      cmd;
    logic [AW-1:0] ptr_q   [PTR_COUNT];
    logic          ptr_adv [PTR_COUNT];

    assign ptr_adv[PTR_WR] = cmd.adv_wr;
    assign ptr_adv[PTR_RD] = cmd.adv_rd;

    for (genvar g = 0; g < PTR_COUNT; g++) begin : g_ptr
        cap_ring_ctr #(.DEPTH(DEPTH)) u_ctr (
            .clk (clk),
            .rst (rst),
            .clr (cmd.clear),
            .adv (ptr_adv[g]),
            .q   (ptr_q[g])
        );
    end

    cap_seq_fsm #(.DEPTH(DEPTH)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start_req   (start_req),
        .stop_req    (stop_req),
        .trig_in     (trig_in),
        .mode_sel    (mode_sel),
        .pretrig_len (pretrig_len),
        .wp          (ptr_q[PTR_WR]),
        .rp          (ptr_q[PTR_RD]),
        .state       (state),
        .cmd         (cmd),
        .wr_en       (wr_en)
    );

    assign state_o = state;
    assign wr_ptr  = ptr_q[PTR_WR];
    assign rd_ptr  = ptr_q[PTR_RD];
endmodule

// File: rtl/cap_seq_checker.sv
module cap_seq_checker #(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst,
    input logic          start_req,
    input logic          stop_req,
    input logic          trig_in,
    input logic [1:0]    mode_sel,
    input logic [2:0]    state_o,
    input logic          wr_en,
    input logic [AW-1:0] wr_ptr,
    input logic [AW-1:0] rd_ptr
);
    logic [AW-1:0] gap;
    logic [AW-1:0] wp_next;

    assign gap     = wr_ptr - rd_ptr;
    assign wp_next = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state_o == 3'd0 && wr_ptr == '0 && rd_ptr == '0 && !wr_en));

    a_r2_enable_after_start: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd0 && start_req && !stop_req && (mode_sel == 2'd0 || mode_sel == 2'd1))
        |=> wr_en);

    a_r3_run_read_held: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd3 && !stop_req) |=> $stable(rd_ptr));

    a_r5_armed_lockstep: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd2 && !trig_in && !stop_req) |=> $stable(gap));

    a_r6_done_ring_relation: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd5) |-> (wp_next == rd_ptr));

    a_r7_incr_enable: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd4) |-> (wr_en == trig_in));

    a_r8_done_quiet: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd5) |-> !wr_en);

    a_r8_done_hold: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd5 && !stop_req) |=> (state_o == 3'd5 && $stable(wr_ptr) && $stable(rd_ptr)));

    a_r9_stop_clears: assert property (@(posedge clk) disable iff (rst)
        stop_req |=> (state_o == 3'd0 && wr_ptr == '0 && rd_ptr == '0));

    a_r10_busy_stays_busy: assert property (@(posedge clk) disable iff (rst)
        (state_o != 3'd0 && !stop_req) |=> (state_o != 3'd0));
endmodule

bind capture_sequencer cap_seq_checker #(.DEPTH(DEPTH)) u_cap_seq_checker (
    .clk       (clk),
    .rst       (rst),
    .start_req (start_req),
    .stop_req  (stop_req),
    .trig_in   (trig_in),
    .mode_sel  (mode_sel),
    .state_o   (state_o),
    .wr_en     (wr_en),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr)
);

// File: tb/test_capture_sequencer.sv
`timescale 1ns/1ps
module test_capture_sequencer;
    localparam int N  = 8;
    localparam int AW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_req = 1'b0;
    logic          stop_req = 1'b0;
    logic          trig_in = 1'b0;
    logic [1:0]    mode_sel = 2'd0;
    logic [AW-1:0] pretrig_len = '0;
    logic [2:0]    state_o;
    logic          wr_en;
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    int ms, mwp, mrd, mmode, mloc;

    always #10 clk = ~clk;

    capture_sequencer #(.DEPTH(N)) i_capture_sequencer (
        .clk(clk), .rst(rst), .start_req(start_req), .stop_req(stop_req),
        .trig_in(trig_in), .mode_sel(mode_sel), .pretrig_len(pretrig_len),
        .state_o(state_o), .wr_en(wr_en), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
    );

    function automatic int nxt(int v);
        return (v + 1) % N;
    endfunction

    function automatic string tag_of(int s, int md);
        case (s)
            0: return "R1";
            1: return "R4";
            2: return "R5";
            3: return (md == 0) ? "R6" : "R3";
            4: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic int exp_en(int s, bit t);
        if (s == 1 || s == 2 || s == 3) return 1;
        if (s == 4) return int'(t);
        return 0;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_step(bit s, bit p, bit t, int m, int l);
        if (p) begin
            ms = 0; mwp = 0; mrd = 0;
        end else begin
            case (ms)
                0: if (s && m != 3) begin
                    mmode = m; mloc = l; mwp = 0; mrd = 0;
                    if (m == 1) ms = 3;
                    else if (m == 2) ms = 4;
                    else ms = (l == 0) ? 2 : 1;
                end
                1: begin
                    if (mwp == mloc - 1) ms = 2;
                    mwp = nxt(mwp);
                end
                2: if (t) begin
                    if (nxt(mwp) == mrd) ms = 5;
                    else begin mwp = nxt(mwp); ms = 3; end
                end else begin
                    mwp = nxt(mwp); mrd = nxt(mrd);
                end
                3: if (nxt(mwp) == mrd) ms = 5; else mwp = nxt(mwp);
                4: if (t) begin
                    if (mwp == N - 1) ms = 5; else mwp = nxt(mwp);
                end
                default: ;
            endcase
        end
    endtask

    task automatic compare_all(bit t);
        string tg;
        tg = tag_of(ms, mmode);
        check(tg, "state", int'(state_o), ms);
        check(tg, "wr_ptr", int'(wr_ptr), mwp);
        check(tg, "rd_ptr", int'(rd_ptr), mrd);
        check(tg, "wr_en", int'(wr_en), exp_en(ms, t));
    endtask

    task automatic cyc(bit s, bit p, bit t, int m, int l);
        @(negedge clk);
        start_req = s; stop_req = p; trig_in = t;
        mode_sel = 2'(m); pretrig_len = AW'(l);
        #1;
        compare_all(t);
        model_step(s, p, t, m, l);
    endtask

    task automatic peek();
        @(posedge clk);
        #2;
    endtask

    task automatic idle(int n, bit t);
        for (int i = 0; i < n; i++) cyc(0, 0, t, 0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; start_req = 0; stop_req = 0; trig_in = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        ms = 0; mwp = 0; mrd = 0; mmode = 0; mloc = 0;
        #1;
        check("R1", "reset state", int'(state_o), 0);
        check("R1", "reset wr_ptr", int'(wr_ptr), 0);
        check("R1", "reset rd_ptr", int'(rd_ptr), 0);
        check("R1", "reset wr_en", int'(wr_en), 0);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        do_reset();

        // R2 / R3: immediate capture
        cyc(1, 0, 0, 1, 0);
        peek();
        check("R2", "wr_en after start", int'(wr_en), 1);
        idle(N + 2, 0);
        peek();
        check("R3", "done state", int'(state_o), 5);
        check("R3", "final wr_ptr", int'(wr_ptr), N - 1);
        check("R3", "final rd_ptr", int'(rd_ptr), 0);

        // R10: start in DONE is ignored
        cyc(1, 0, 0, 2, 0);
        peek();
        check("R10", "state after start in DONE", int'(state_o), 5);
        cyc(0, 1, 0, 0, 0);
        peek();
        check("R9", "state after stop", int'(state_o), 0);

        // R6: trigger already high at end of fill
        cyc(1, 0, 1, 0, 4);
        idle(N + 4, 1);
        peek();
        check("R6", "no-wait final wr_ptr", int'(wr_ptr), N - 1);
        check("R6", "no-wait state", int'(state_o), 5);
        cyc(0, 1, 0, 0, 0);

        // R5 / R6: wait for trigger, pointers wrap
        cyc(1, 0, 0, 0, 3);
        idle(13, 0);
        cyc(0, 0, 1, 0, 0);
        idle(N, 0);
        peek();
        check("R6", "ring relation", (int'(wr_ptr) + 1) % N, int'(rd_ptr));
        check("R6", "waited state", int'(state_o), 5);
        cyc(0, 1, 0, 0, 0);

        // R4: zero-length window and maximal window
        cyc(1, 0, 0, 0, 0);
        peek();
        check("R4", "zero length goes armed", int'(state_o), 2);
        idle(5, 0);
        cyc(0, 0, 1, 0, 0);
        idle(N, 0);
        cyc(0, 1, 0, 0, 0);
        cyc(1, 0, 0, 0, N - 1);
        idle(N + 3, 0);
        cyc(0, 0, 1, 0, 0);
        peek();
        check("R6", "max window done on trigger", int'(state_o), 5);
        cyc(0, 1, 0, 0, 0);

        // R7: incremental mode
        cyc(1, 0, 0, 2, 0);
        for (int i = 0; i < 3 * N; i++) cyc(0, 0, (i % 3) == 1, 0, 0);
        peek();
        check("R7", "incremental final wr_ptr", int'(wr_ptr), N - 1);
        check("R7", "incremental state", int'(state_o), 5);
        cyc(0, 1, 0, 0, 0);

        // R2: reserved mode ignored; R9: stop beats start
        cyc(1, 0, 0, 3, 0);
        peek();
        check("R2", "reserved mode stays idle", int'(state_o), 0);
        cyc(1, 1, 0, 1, 0);
        peek();
        check("R9", "stop over start", int'(state_o), 0);

        // R10: start during RUN ignored
        cyc(1, 0, 0, 1, 0);
        idle(2, 0);
        cyc(1, 0, 0, 2, 0);
        peek();
        check("R10", "start during run", int'(state_o), 3);
        check("R10", "wr_ptr during run", int'(wr_ptr), 3);

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            cyc(($urandom % 8) == 0, ($urandom % 50) == 0, ($urandom % 3) == 0,
                int'($urandom % 4), int'($urandom % N));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule